// File: doc/BRIEF.md
# Colour LCD Controller Register Interface

This block is the software-visible register file of a colour LCD controller. It sits on an APB-style bus and decodes word-aligned offsets inside a 4 KB window. It stores the panel timing words, the two frame-base addresses, the interrupt mask and the control word. It also holds a 128-word colour palette and answers a fixed identification area.

From the stored words it continuously drives the geometry and format signals used by the rest of the controller: the active pixels per line, the lines per panel, the bits-per-pixel code, two endianness flags and a display-enable level. Interrupt sources arrive as single-cycle pulses and are latched into sticky status bits. These bits are masked and combined into one interrupt line. Any write to a timing or control word raises a one-cycle pulse, so that downstream logic can redraw the frame.

Every access completes in the access phase with no wait states. Read data is driven combinationally while `psel` is high and `pwrite` is low.

Top module: `lcd_regif`

## Requirements
- R1: Word offsets 0x000, 0x004, 0x008 and 0x00C (timing 0..3), 0x010 (upper base) and 0x014 (lower base) read back the full 32-bit value last written. Offset 0x018 (mask) keeps the low NIRQ bits and offset 0x01C (control) keeps the low CTRL_W bits; both read with zeros above.
- R2: Offset 0x020 reads the raw interrupt status and 0x024 reads the raw status ANDed with the mask. `irq` is high exactly when at least one masked status bit is set.
- R3: A write to 0x028 clears each status bit whose position is 1 in the write data. When a source pulse and a clear hit the same bit in the same cycle, the bit stays set. Offset 0x028 reads as zero.
- R4: `line_pixels` equals ((timing0 & 0xFC) + 4) * 4. It ranges from 16 to 1024.
- R5: `panel_lines` equals (timing1 & 0x3FF) + 1. It ranges from 1 to 1024.
- R6: In the control word, bit 0 is enable, bit 11 is power, bits 3:1 give `bpp_code`, bit 9 drives `byte_be` and bit 10 drives `pix_be`. `disp_en` is high only when bits 0 and 11 are both 1.
- R7: A high `irq_src[k]` in any cycle sets status bit k at that clock edge. The bit stays set until it is cleared through 0x028.
- R8: `inval_pulse` is high for exactly the one cycle that follows the write edge of an access to offsets 0x000 to 0x00C or 0x01C. At all other times it is low.
- R9: Offsets 0x200 to 0x3FC address 128 palette words, word (offset-0x200)>>2, and each word reads back the value last written.
- R10: Offsets 0xFE0 to 0xFFC each read one identification byte in bits 7:0: 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in ascending offset order.
- R11: Unmapped offsets read zero, and writes to them change no register. `pslverr` is always low and `pready` is always high.
- R12: After reset, every register and status bit is zero, `irq`, `disp_en` and `inval_pulse` are low, `line_pixels` is 16 and `panel_lines` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte offset in the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer ready, always 1 |
| pslverr | output | 1 | Transfer error, always 0 |
| irq_src | input | NIRQ | Interrupt source pulses |
| irq | output | 1 | OR of masked status bits |
| line_pixels | output | 11 | Decoded pixels per line |
| panel_lines | output | 11 | Decoded lines per panel |
| bpp_code | output | 3 | Bits-per-pixel code |
| byte_be | output | 1 | Big-endian byte order selected |
| pix_be | output | 1 | Big-endian pixel order selected |
| disp_en | output | 1 | Enable and power both set |
| inval_pulse | output | 1 | One-cycle pulse after a timing or control write |

## Verification
The bench drives timing fields at their extremes (0x00, 0x03, 0xFF and an all-ones line field). This catches a decoder that drops the +4 or +1 offset, overflows at 1024 or fails to mask the ignored low bits. It sets the enable and power bits one at a time and then together, which exposes an enable that uses only one of them. It sends a source pulse into the same cycle as a clear of that bit; a design that gives the clear priority would lose the event. It writes an unmapped offset and then reads back the neighbouring state, and it checks that the invalidate pulse is absent after a mask write. This catches a decoder that aliases or over-matches offsets.

// File: rtl/lcd_regif_pkg.sv
package lcd_regif_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int IDX_W  = ADDR_W - 2;
  localparam int LPW    = 11;

  localparam logic [IDX_W-1:0] IX_TIM0 = 10'd0;
  localparam logic [IDX_W-1:0] IX_TIM3 = 10'd3;
  localparam logic [IDX_W-1:0] IX_UBAS = 10'd4;
  localparam logic [IDX_W-1:0] IX_LBAS = 10'd5;
  localparam logic [IDX_W-1:0] IX_MASK = 10'd6;
  localparam logic [IDX_W-1:0] IX_CTRL = 10'd7;
  localparam logic [IDX_W-1:0] IX_RAW  = 10'd8;
  localparam logic [IDX_W-1:0] IX_MSK  = 10'd9;
  localparam logic [IDX_W-1:0] IX_CLR  = 10'd10;
  localparam int               PAL_BASE_IX = 'h80;

  function automatic logic [7:0] id_byte(input logic [2:0] k);
    case (k)
      3'd0:    id_byte = 8'h10;
      3'd1:    id_byte = 8'h11;
      3'd2:    id_byte = 8'h04;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/lcd_rst_sync.sv
module lcd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/lcd_irq_ctrl.sv
module lcd_irq_ctrl #(
  parameter int NIRQ = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] src,
  input  logic            clr_en,
  input  logic [NIRQ-1:0] clr_val,
  input  logic [NIRQ-1:0] mask,
  output logic [NIRQ-1:0] status,
  output logic            irq
);
  logic [NIRQ-1:0] status_d;
  logic [NIRQ-1:0] clr_bits;

  always_comb begin
    clr_bits = clr_en ? clr_val : '0;
    status_d = (status & ~clr_bits) | src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= status_d;
  end

  assign irq = |(status & mask);
endmodule

// File: rtl/lcd_palette.sv
module lcd_palette #(
  parameter int DEPTH = 128,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[addr] <= wdata;
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/lcd_geom_decode.sv
module lcd_geom_decode
  import lcd_regif_pkg::*;
#(
  parameter int CTRL_W = 16
) (
  input  logic [7:2]        tim0_ppl,
  input  logic [9:0]        tim1_lpp,
  input  logic [CTRL_W-1:0] ctrl,
  output logic [LPW-1:0]    line_pixels,
  output logic [LPW-1:0]    panel_lines,
  output logic [2:0]        bpp_code,
  output logic              byte_be,
  output logic              pix_be,
  output logic              disp_en
);
  always_comb begin
    line_pixels = (LPW'(tim0_ppl) + LPW'(1)) << 4;
    panel_lines = LPW'(tim1_lpp) + LPW'(1);
    bpp_code    = ctrl[3:1];
    byte_be     = ctrl[9];
    pix_be      = ctrl[10];
    disp_en     = ctrl[0] & ctrl[11];
  end
endmodule

// File: rtl/lcd_regif.sv
module lcd_regif
  import lcd_regif_pkg::*;
#(
  parameter int NIRQ      = 5,
  parameter int CTRL_W    = 16,
  parameter int PAL_DEPTH = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [NIRQ-1:0]   irq_src,
  output logic              irq,
  output logic [LPW-1:0]    line_pixels,
  output logic [LPW-1:0]    panel_lines,
  output logic [2:0]        bpp_code,
  output logic              byte_be,
  output logic              pix_be,
  output logic              disp_en,
  output logic              inval_pulse
);
  localparam int PAW = $clog2(PAL_DEPTH);

  logic              rst_sync_n;
  logic [IDX_W-1:0]  idx;
  logic              wr_acc;
  logic              pal_hit, id_hit;
  logic [3:0]        tim_en;
  logic              ubas_en, lbas_en, mask_en, ctrl_en, clr_en;
  logic [DATA_W-1:0] tim_q [4];
  logic [DATA_W-1:0] ubas_q, lbas_q;
  logic [NIRQ-1:0]   mask_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              inval_d;
  logic [NIRQ-1:0]   irq_status;
  logic [DATA_W-1:0] pal_rdata;
  logic [PAW-1:0]    pal_addr;

  lcd_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  // address decode
  always_comb begin
    idx     = paddr[ADDR_W-1:2];
    wr_acc  = psel & penable & pwrite;
    pal_hit = (int'(idx) >= PAL_BASE_IX) && (int'(idx) < PAL_BASE_IX + PAL_DEPTH);
    id_hit  = (idx[IDX_W-1:3] == '1);
    pal_addr = PAW'(int'(idx) - PAL_BASE_IX);
    for (int i = 0; i < 4; i++) tim_en[i] = wr_acc && (idx == IX_TIM0 + IDX_W'(i));
    ubas_en = wr_acc && (idx == IX_UBAS);
    lbas_en = wr_acc && (idx == IX_LBAS);
    mask_en = wr_acc && (idx == IX_MASK);
    ctrl_en = wr_acc && (idx == IX_CTRL);
    clr_en  = wr_acc && (idx == IX_CLR);
    inval_d = (|tim_en) | ctrl_en;
  end

  // register state with explicit clock enables
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int i = 0; i < 4; i++) tim_q[i] <= '0;
      ubas_q      <= '0;
      lbas_q      <= '0;
      mask_q      <= '0;
      ctrl_q      <= '0;
      inval_pulse <= 1'b0;
    end else begin
      for (int i = 0; i < 4; i++) if (tim_en[i]) tim_q[i] <= pwdata;
      if (ubas_en) ubas_q <= pwdata;
      if (lbas_en) lbas_q <= pwdata;
      if (mask_en) mask_q <= pwdata[NIRQ-1:0];
      if (ctrl_en) ctrl_q <= pwdata[CTRL_W-1:0];
      inval_pulse <= inval_d;
    end
  end

  lcd_irq_ctrl #(.NIRQ(NIRQ)) u_irq (
    .clk(clk), .rst_n(rst_sync_n), .src(irq_src), .clr_en(clr_en),
    .clr_val(pwdata[NIRQ-1:0]), .mask(mask_q), .status(irq_status), .irq(irq)
  );

  lcd_palette #(.DEPTH(PAL_DEPTH), .W(DATA_W)) u_pal (
    .clk(clk), .we(wr_acc & pal_hit), .addr(pal_addr), .wdata(pwdata), .rdata(pal_rdata)
  );

  lcd_geom_decode #(.CTRL_W(CTRL_W)) u_geom (
    .tim0_ppl(tim_q[0][7:2]), .tim1_lpp(tim_q[1][9:0]), .ctrl(ctrl_q),
    .line_pixels(line_pixels), .panel_lines(panel_lines), .bpp_code(bpp_code),
    .byte_be(byte_be), .pix_be(pix_be), .disp_en(disp_en)
  );

  // read mux
  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      if (pal_hit)     prdata = pal_rdata;
      else if (id_hit) prdata = DATA_W'(id_byte(idx[2:0]));
      else begin
        case (idx)
          IX_TIM0, 10'd1, 10'd2, IX_TIM3: prdata = tim_q[idx[1:0]];
          IX_UBAS: prdata = ubas_q;
          IX_LBAS: prdata = lbas_q;
          IX_MASK: prdata = DATA_W'(mask_q);
          IX_CTRL: prdata = DATA_W'(ctrl_q);
          IX_RAW:  prdata = DATA_W'(irq_status);
          IX_MSK:  prdata = DATA_W'(irq_status & mask_q);
          default: prdata = '0;
        endcase
      end
    end
  end

  assign pready  = 1'b1;
  assign pslverr = 1'b0;
endmodule

// File: rtl/lcd_regif_chk.sv
module lcd_regif_chk #(
  parameter int NIRQ = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            psel,
  input logic            penable,
  input logic            pwrite,
  input logic [11:0]     paddr,
  input logic [31:0]     pwdata,
  input logic [NIRQ-1:0] irq_src,
  input logic [NIRQ-1:0] status,
  input logic [10:0]     line_pixels,
  input logic            disp_en,
  input logic            inval_pulse
);
  logic wr, wr_ctl;
  assign wr     = psel && penable && pwrite;
  assign wr_ctl = wr && (paddr[11:4] == 8'h00 || paddr[11:2] == 10'd7);

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr[11:2] == 10'd10 && (&pwdata[NIRQ-1:0]) && irq_src == '0) |=> (status == '0)); // R3
  AST_WIDTH_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr[11:2] == 10'd0) |=> (line_pixels == ((11'($past(pwdata[7:2])) + 11'd1) << 4))); // R4
  AST_EN_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr[11:2] == 10'd7) |=> (disp_en == ($past(pwdata[0]) && $past(pwdata[11])))); // R6
  AST_SRC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_src != '0) |=> ((status & $past(irq_src)) == $past(irq_src))); // R7
  AST_INVAL_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> inval_pulse); // R8
  AST_INVAL_ONLY_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctl |=> !inval_pulse); // R8
endmodule

bind lcd_regif lcd_regif_chk #(.NIRQ(NIRQ)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .irq_src(irq_src), .status(irq_status),
  .line_pixels(line_pixels), .disp_en(disp_en), .inval_pulse(inval_pulse)
);

// File: tb/lcd_regif_tb_top.sv
module lcd_regif_tb_top;
  localparam int NIRQ = 5;
  localparam int NVEC = 34;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        psel, penable, pwrite;
  logic [11:0] paddr;
  logic [31:0] pwdata, prdata;
  logic        pready, pslverr;
  logic [NIRQ-1:0] irq_src;
  logic        irq;
  logic [10:0] line_pixels, panel_lines;
  logic [2:0]  bpp_code;
  logic        byte_be, pix_be, disp_en, inval_pulse;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  lcd_regif #(.NIRQ(NIRQ)) dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .irq_src(irq_src), .irq(irq), .line_pixels(line_pixels), .panel_lines(panel_lines),
    .bpp_code(bpp_code), .byte_be(byte_be), .pix_be(pix_be), .disp_en(disp_en),
    .inval_pulse(inval_pulse)
  );

  // {write, offset, data-or-expected}
  localparam logic [44:0] VEC [NVEC] = '{
    {1'b1, 12'h000, 32'h0000_00A7}, {1'b0, 12'h000, 32'h0000_00A7},
    {1'b1, 12'h004, 32'h0000_0123}, {1'b0, 12'h004, 32'h0000_0123},
    {1'b1, 12'h008, 32'hDEAD_BEEF}, {1'b0, 12'h008, 32'hDEAD_BEEF},
    {1'b1, 12'h00C, 32'h1234_5678}, {1'b0, 12'h00C, 32'h1234_5678},
    {1'b1, 12'h010, 32'h8000_1000}, {1'b0, 12'h010, 32'h8000_1000},
    {1'b1, 12'h014, 32'h8000_2000}, {1'b0, 12'h014, 32'h8000_2000},
    {1'b1, 12'h018, 32'hFFFF_FFFF}, {1'b0, 12'h018, 32'h0000_001F},
    {1'b1, 12'h01C, 32'h0000_0E0B}, {1'b0, 12'h01C, 32'h0000_0E0B},
    {1'b1, 12'h200, 32'h1111_1111}, {1'b1, 12'h3FC, 32'h2222_2222},
    {1'b1, 12'h280, 32'h3333_3333}, {1'b0, 12'h200, 32'h1111_1111},
    {1'b0, 12'h3FC, 32'h2222_2222}, {1'b0, 12'h280, 32'h3333_3333},
    {1'b0, 12'hFE0, 32'h10}, {1'b0, 12'hFE4, 32'h11},
    {1'b0, 12'hFE8, 32'h04}, {1'b0, 12'hFEC, 32'h00},
    {1'b0, 12'hFF0, 32'h0D}, {1'b0, 12'hFF4, 32'hF0},
    {1'b0, 12'hFF8, 32'h05}, {1'b0, 12'hFFC, 32'hB1},
    {1'b1, 12'h100, 32'hFFFF_FFFF}, {1'b0, 12'h100, 32'h0},
    {1'b0, 12'h028, 32'h0}, {1'b0, 12'h000, 32'h0000_00A7}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d, output logic err);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1;
    d = prdata;
    err = pslverr | ~pready;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  function automatic string tag_of(input logic [11:0] a);
    if (a >= 12'hFE0) return "R10";
    if (a >= 12'h200 && a < 12'h400) return "R9";
    if (a == 12'h028) return "R3";
    if (a < 12'h020) return "R1";
    return "R11";
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic err;
    psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0; irq_src = '0;
    rst_n = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R12 reset state
    @(negedge clk);
    chk("R12 irq", irq, 0);
    chk("R12 disp_en", disp_en, 0);
    chk("R12 inval", inval_pulse, 0);
    chk("R12 line_pixels", line_pixels, 16);
    chk("R12 panel_lines", panel_lines, 1);
    apb_rd(12'h000, rd, err); chk("R12 timing0", rd, 0);
    apb_rd(12'h01C, rd, err); chk("R12 ctrl", rd, 0);
    apb_rd(12'h020, rd, err); chk("R12 status", rd, 0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][44]) apb_wr(VEC[i][43:32], VEC[i][31:0]);
      else begin
        apb_rd(VEC[i][43:32], rd, err);
        chk(tag_of(VEC[i][43:32]), rd, VEC[i][31:0]);
      end
    end
    apb_rd(12'h030, rd, err);
    chk("R11 unmapped read", rd, 0);
    chk("R11 pslverr/pready", err, 0);

    // geometry and format from table values
    chk("R4 width 0xA7", line_pixels, 672);
    chk("R5 lines 0x123", panel_lines, 292);
    chk("R6 bpp", bpp_code, 5);
    chk("R6 byte_be", byte_be, 1);
    chk("R6 pix_be", pix_be, 1);
    chk("R6 enable", disp_en, 1);

    // R8 invalidate pulse
    apb_wr(12'h018, 32'h1F);
    chk("R8 no pulse after mask write", inval_pulse, 0);
    apb_wr(12'h01C, 32'h001);
    chk("R8 pulse after ctrl write", inval_pulse, 1);
    @(negedge clk);
    chk("R8 pulse one cycle", inval_pulse, 0);
    chk("R6 enable without power", disp_en, 0);
    apb_wr(12'h01C, 32'h800);
    chk("R6 power without enable", disp_en, 0);
    apb_wr(12'h01C, 32'h801);
    chk("R6 both set", disp_en, 1);
    chk("R6 byte_be clear", byte_be, 0);
    chk("R6 bpp zero", bpp_code, 0);

    // R4 / R5 extremes
    apb_wr(12'h000, 32'hFF);
    chk("R4 width max", line_pixels, 1024);
    chk("R8 pulse after timing write", inval_pulse, 1);
    apb_wr(12'h000, 32'h03);
    chk("R4 width low bits ignored", line_pixels, 16);
    apb_wr(12'h004, 32'hFFFF_FFFF);
    chk("R5 lines max", panel_lines, 1024);
    apb_wr(12'h004, 32'h0);
    chk("R5 lines min", panel_lines, 1);

    // R7 / R2 / R3 interrupts
    apb_wr(12'h018, 32'h05);
    @(negedge clk) irq_src = 5'b00011;
    @(negedge clk) irq_src = '0;
    chk("R2 irq on masked bit", irq, 1);
    apb_rd(12'h020, rd, err); chk("R7 raw sticky", rd, 32'h3);
    apb_rd(12'h024, rd, err); chk("R2 masked status", rd, 32'h1);
    apb_wr(12'h028, 32'h1);
    apb_rd(12'h020, rd, err); chk("R3 clear bit0", rd, 32'h2);
    chk("R2 irq low with unmasked only", irq, 0);
    irq_src = 5'b00100;
    apb_wr(12'h028, 32'h4);
    irq_src = '0;
    apb_rd(12'h020, rd, err); chk("R3 set wins over clear", rd, 32'h6);
    chk("R2 irq from bit2", irq, 1);
    apb_wr(12'h028, 32'h1F);
    apb_rd(12'h020, rd, err); chk("R3 clear all", rd, 0);
    chk("R3 irq low", irq, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule